// File: doc/BRIEF.md
# XOR-Encoded One-Write One-Read Memory

This block gives one write port and one read port that can both be used in the same clock cycle. It is built only from single-port synchronous arrays, and it has no flop-based table that records which copy holds the newest value. The storage is split into two banks, and the read result is the bitwise XOR of what the two banks hold at the requested address. A write goes to the bank picked by the cycle-parity phase bit. It first fetches the opposite bank's word at the same address, then stores `new ^ opposite` into its own bank. When both banks are XORed later, the new word comes back out.

Each bank has three arrays. The first two are a phased pair: one can be read while the other is being written, so the bank can serve the read port on every cycle. The third is a spare copy. It answers the lookups made by writes into the other bank, and it only has to do so on alternate cycles.

Single-port arrays come up with arbitrary contents, and a word is only consistent once both banks agree on it. For that reason a fill sequencer runs after reset. It writes zero into every location of all six arrays, and requests are ignored until it raises its done flag. Two-deep forwarding hides the write pipeline, so a read on any cycle after a write sees the new word.

Top module: `xor2p_mem`

## Requirements
- R1: After reset is released, `init_done` stays low for exactly 2**ADDR_W clock cycles, then goes high and remains high until the next reset.
- R2: Once `init_done` is high, a read of any address that has not been written since reset returns zero.
- R3: While `init_done` is low, `rd_en` produces no `rd_valid`, and `wr_en` leaves the stored contents unchanged.
- R4: A read accepted on cycle r (`rd_en` high while `init_done` is high) raises `rd_valid` on cycle r+1, with the result on `rd_data` in that same cycle. `rd_valid` is low in every other cycle.
- R5: A read returns the data of the most recent write to the same address that was accepted on an earlier cycle, no matter how many cycles earlier that write was.
- R6: A read and a write to the same address on the same cycle return the value held before that write.
- R7: A read issued one, two or three cycles after a write to the same address returns the new data, even though the second step of the write has not yet reached the arrays.
- R8: A write can be accepted on every cycle, including consecutive writes to one address. Consecutive writes go to alternate banks, selected by the phase bit.
- R9: A bank's primary and spare arrays are written only in the phase that bank owns. Its copy array is written only in the other phase. No array receives a read and a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read result present on `rd_data` |
| rd_data | output | WIDTH | Read result |
| init_done | output | 1 | Zero fill finished; requests are accepted |

## Verification
Read results are due exactly one cycle after the request. The scoreboard therefore captures the expected word from its reference array when the request is driven, before that cycle's own write is applied, and it compares on the `rd_valid` cycle in FIFO order. Each queued item carries its requirement tag. `init_done` is due after exactly 2**ADDR_W cycles, and it is sampled on the falling edge of the cycle before and of the cycle after that rise. Writes followed by reads at distances of 0 to 4 cycles cover both the forwarding window and the first cycle served purely by the arrays.

// File: rtl/xor2p_pkg.sv
// Shared types for the XOR-encoded two-port memory.
package xor2p_pkg;
    // Zero-fill sequencer states.
    typedef enum logic {
        SEQ_FILL = 1'b0,
        SEQ_IDLE = 1'b1
    } seq_state_t;
endpackage

// File: rtl/sram_1rw.sv
// Single-port synchronous array: one read or one write per cycle.
// Read data is registered (one-cycle latency). The array has no reset,
// so its contents are arbitrary until they are written.
module sram_1rw #(
    parameter int WIDTH  = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] mem [DEPTH];

    // Perform the single access of this cycle.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/xor2p_fill.sv
// Zero-fill sequencer. After reset it walks the addresses in ascending
// order, one per cycle, then raises done and stays idle.
// Assumes the depth is a power of two.
module xor2p_fill
    import xor2p_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              fill_en,
    output logic [ADDR_W-1:0] fill_addr,
    output logic              done
);
    seq_state_t        state;
    logic [ADDR_W-1:0] cnt;

    // Advance the fill pointer and stop after the last address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_FILL;
            cnt   <= '0;
        end else if (state == SEQ_FILL) begin
            cnt <= cnt + 1'b1;
            if (&cnt) state <= SEQ_IDLE;
        end
    end

    assign fill_en   = (state == SEQ_FILL);
    assign fill_addr = cnt;
    assign done      = (state == SEQ_IDLE);

    // R1
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
endmodule

// File: rtl/xor2p_bank.sv
// One bank made of three single-port arrays:
//   prim  - takes commits in the owned phase, serves reads in the other phase
//   copy  - repeats each commit one cycle later, serves reads in the owned phase
//   spare - takes commits in the owned phase, answers the opposite bank's
//           lookups in the other phase
// Assumes the caller schedules commits, copies and lookups by phase.
module xor2p_bank #(
    parameter int   WIDTH   = 16,
    parameter int   ADDR_W  = 5,
    parameter bit   BANK_ID = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_word,
    input  logic              cm_en,
    input  logic [ADDR_W-1:0] cm_addr,
    input  logic [WIDTH-1:0]  cm_data,
    input  logic              cp_en,
    input  logic [ADDR_W-1:0] cp_addr,
    input  logic [WIDTH-1:0]  cp_data,
    input  logic              lk_en,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic [WIDTH-1:0]  lk_word
);
    logic              own;
    logic              prim_en, copy_en, spare_en;
    logic [ADDR_W-1:0] prim_addr, copy_addr, spare_addr;
    logic [WIDTH-1:0]  prim_q, copy_q;
    logic              sel_copy_q;

    assign own = (phase == BANK_ID);

    // Port controls for the three arrays; the fill takes priority.
    always_comb begin
        prim_en    = fill_en | cm_en | (rd_en & ~own);
        prim_addr  = fill_en ? fill_addr : (cm_en ? cm_addr : rd_addr);
        copy_en    = fill_en | cp_en | (rd_en & own);
        copy_addr  = fill_en ? fill_addr : (cp_en ? cp_addr : rd_addr);
        spare_en   = fill_en | cm_en | lk_en;
        spare_addr = fill_en ? fill_addr : (cm_en ? cm_addr : lk_addr);
    end

    sram_1rw #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_prim (
        .clk(clk), .en(prim_en), .we(fill_en | cm_en), .addr(prim_addr),
        .wdata(fill_en ? '0 : cm_data), .rdata(prim_q));

    sram_1rw #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_copy (
        .clk(clk), .en(copy_en), .we(fill_en | cp_en), .addr(copy_addr),
        .wdata(fill_en ? '0 : cp_data), .rdata(copy_q));

    sram_1rw #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_spare (
        .clk(clk), .en(spare_en), .we(fill_en | cm_en), .addr(spare_addr),
        .wdata(fill_en ? '0 : cm_data), .rdata(lk_word));

    // Remember which array served this cycle's read.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_copy_q <= 1'b0;
        else        sel_copy_q <= own;
    end

    assign rd_word = sel_copy_q ? copy_q : prim_q;

    // R9
    commit_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_en |-> own);
    // R9
    copy_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_en |-> !own);
    // R9
    spare_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cm_en && lk_en));
    // R3
    fill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !(rd_en || lk_en || cm_en || cp_en));
endmodule

// File: rtl/xor2p_mem.sv
// One-write one-read memory built from six single-port arrays in two
// XOR-encoded banks. A write accepted on cycle t in phase p looks up bank !p
// on cycle t, computes new^old on t+1, commits to bank p on t+2 and copies
// it on t+3. Reads return bank0^bank1 one cycle later, with the two newest
// writes forwarded.
module xor2p_mem #(
    parameter int WIDTH  = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [WIDTH-1:0]  rd_data,
    output logic              init_done
);
    logic              phase;
    logic              wr_go, rd_go;
    logic              fill_en;
    logic [ADDR_W-1:0] fill_addr;

    // Write pipeline stages.
    logic              v1, b1, v2, b2, v3, b3;
    logic [ADDR_W-1:0] a1, a2, a3;
    logic [WIDTH-1:0]  d1, d2, x2, x3;
    logic [WIDTH-1:0]  other, x1;

    logic [WIDTH-1:0]  bank_rd [2];
    logic [WIDTH-1:0]  bank_lk [2];
    logic              fwd_hit_q;
    logic [WIDTH-1:0]  fwd_q;

    assign wr_go = wr_en & init_done;
    assign rd_go = rd_en & init_done;

    xor2p_fill #(.ADDR_W(ADDR_W)) u_fill (
        .clk(clk), .rst_n(rst_n), .fill_en(fill_en),
        .fill_addr(fill_addr), .done(init_done));

    // Cycle-parity phase bit that picks the bank for each write.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end

    // Opposite-bank word, forwarded from the previous write if it is still in flight.
    always_comb begin
        other = (v2 && a2 == a1) ? x2 : bank_lk[~b1];
        x1    = d1 ^ other;
    end

    // Shift accepted writes through lookup, encode, commit and copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
        end else begin
            v1 <= wr_go; v2 <= v1; v3 <= v2;
        end
        b1 <= phase;   a1 <= wr_addr; d1 <= wr_data;
        b2 <= b1;      a2 <= a1;      d2 <= d1;      x2 <= x1;
        b3 <= b2;      a3 <= a2;      x3 <= x2;
    end

    for (genvar k = 0; k < 2; k++) begin : g_bank
        xor2p_bank #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .BANK_ID(k == 1)) u_bank (
            .clk(clk), .rst_n(rst_n), .phase(phase),
            .fill_en(fill_en), .fill_addr(fill_addr),
            .rd_en(rd_go), .rd_addr(rd_addr), .rd_word(bank_rd[k]),
            .cm_en(v2 && (b2 == (k == 1))), .cm_addr(a2), .cm_data(x2),
            .cp_en(v3 && (b3 == (k == 1))), .cp_addr(a3), .cp_data(x3),
            .lk_en(wr_go && (phase != (k == 1))), .lk_addr(wr_addr),
            .lk_word(bank_lk[k]));
    end

    // Capture read valid and the forwarding choice (newest write first).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            fwd_hit_q <= 1'b0;
        end else begin
            rd_valid  <= rd_go;
            fwd_hit_q <= (v1 && a1 == rd_addr) || (v2 && a2 == rd_addr);
        end
        fwd_q <= (v1 && a1 == rd_addr) ? d1 : d2;
    end

    assign rd_data = fwd_hit_q ? fwd_q : (bank_rd[0] ^ bank_rd[1]);

    // R4
    rvalid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && init_done) |=> rd_valid);
    // R4
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && init_done) |=> !rd_valid);
    // R3
    init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !rd_valid);
    // R8
    alt_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v1 && v2) |-> (b1 != b2));
    // R7
    fwd_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && init_done && v1 && rd_addr == a1) |=> (rd_data == $past(wr_data, 2)));
endmodule

// File: tb/xor2p_mem_tb.sv
`timescale 1ns/1ps
module xor2p_mem_tb;
    localparam int W     = 16;
    localparam int AW    = 5;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic          rd_valid, init_done;
    logic [W-1:0]  rd_data;

    int            checks = 0, fails = 0;
    logic [W-1:0]  ref_mem [DEPTH];
    logic [W-1:0]  exp_q [$];
    string         tag_q [$];

    always #2.5 clk = ~clk;

    xor2p_mem #(.WIDTH(W), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .init_done(init_done));

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; queues the expected read result.
    task automatic op(input bit we, input logic [AW-1:0] wa, input logic [W-1:0] wd,
                      input bit re, input logic [AW-1:0] ra, input string req);
        @(negedge clk);
        #0.5;
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_en = re; rd_addr = ra;
        if (init_done) begin
            if (re) begin
                exp_q.push_back(ref_mem[ra]);
                tag_q.push_back(req);
            end
            if (we) ref_mem[wa] = wd;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(0, '0, '0, 0, '0, "");
    endtask

    // Monitor: compares each returned word against the queue.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R4: unexpected rd_valid, got %h expected none", rd_data);
            end else begin
                logic [W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rd_data, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1, R3: during the fill, drive a read and a write every cycle.
        for (int c = 1; c <= DEPTH; c++) begin
            @(posedge clk);
            #0.5;
            wr_en = 1'b1; wr_addr = 5'd3; wr_data = 16'hBEEF;
            rd_en = 1'b1; rd_addr = 5'd3;
            @(negedge clk);
            if (c < DEPTH) check("R1", {15'd0, init_done}, 16'd0);
            else           check("R1", {15'd0, init_done}, 16'd1);
            check("R3", {15'd0, rd_valid}, 16'd0);
        end
        wr_en = 1'b0; rd_en = 1'b0;
        // R2, R3: every location reads zero, including the one written during the fill.
        for (int a = 0; a < DEPTH; a++) op(0, '0, '0, 1, a[AW-1:0], a == 3 ? "R3" : "R2");
        idle(2);
        // R7: read 1, 2, 3 cycles after a write; R5: 4 cycles after.
        for (int gap = 1; gap <= 4; gap++) begin
            op(1, 5'd7, 16'h1000 + 16'(gap), 0, '0, "");
            if (gap > 1) idle(gap - 1);
            op(0, '0, '0, 1, 5'd7, gap == 4 ? "R5" : "R7");
            idle(3);
        end
        // R6: same-cycle read of the written address returns the prior value.
        op(1, 5'd9, 16'hA5A5, 0, '0, "");
        idle(4);
        op(1, 5'd9, 16'h5A5A, 1, 5'd9, "R6");
        op(0, '0, '0, 1, 5'd9, "R7");
        idle(3);
        // R8, R9: back-to-back writes to one address, alternating banks, then reads.
        for (int i = 0; i < 6; i++) op(1, 5'd12, 16'hC000 + 16'(i), 1, 5'd12, "R8");
        for (int i = 0; i < 5; i++) op(0, '0, '0, 1, 5'd12, "R8");
        idle(2);
        // R5: random mixed traffic over a narrow address range.
        for (int i = 0; i < 3000; i++) begin
            op($urandom_range(0, 1) == 1, 5'($urandom_range(0, 5)), 16'($urandom),
               $urandom_range(0, 1) == 1, 5'($urandom_range(0, 5)), "R5");
        end
        idle(3);
        // R5: final sweep of the whole array.
        for (int a = 0; a < DEPTH; a++) op(0, '0, '0, 1, a[AW-1:0], "R5");
        idle(4);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R4: got %0d pending reads expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule